// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one pulse-width-modulation channel. It is built on a 10-bit up-counter that a programmable prescaler steps forward. The prescaler counts clock-enable pulses that come from outside, so the base count rate is set elsewhere in the chip. A select code picks a division ratio from 2 to 256. The counter runs from zero up to the period value and then starts again. One full cycle therefore lasts the period value plus one prescaled ticks.

Software may write the duty value at any time. That write only lands in a holding register. The value moves into the active duty latch at the next period boundary, so a cycle that is already running is never cut short or stretched. At each boundary the output goes high, unless the newly latched duty is zero. The output goes low when the counter reaches the latched duty. A sticky flag records every period boundary and stays set until software clears it. The counter value can be read but not written. Clearing the enable input stops the channel and parks it at zero.

Top module: `pwm_timer_channel`

## Requirements
- R1: After reset the counter reads 0, the PWM output is low and the period flag is clear.
- R2: With select code s (0 to 7), the counter takes one step for every 2^(s+1) clock cycles in which cntEn is high. Code 0 divides by 2 and code 7 divides by 256. Cycles with cntEn low do not advance the prescaler or the counter.
- R3: On a tick where the counter equals periodVal, the counter returns to 0. On any other tick it adds one. One cycle is periodVal+1 ticks.
- R4: On a period-boundary tick, dutyVal is copied into the active duty latch. The output goes high if the copied value is nonzero and low if it is zero.
- R5: The output goes low on the tick that brings the counter to the latched duty. A latched duty of periodVal+1 or more keeps the output high for the whole cycle. A latched duty of 0 keeps it low.
- R6: A change of dutyVal in the middle of a cycle leaves that cycle's high time unchanged. The new value governs the cycle that starts at the next boundary.
- R7: The period flag is set by every boundary tick and holds until flagClear is high. If a boundary tick and flagClear arrive in the same cycle, the flag ends up set.
- R8: While chanEnable is low, the prescaler and counter are held at 0 and the output is low. The period flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Base count-enable pulse fed to the prescaler |
| chanEnable | input | 1 | Channel run enable; low stops and clears the channel |
| preSel | input | 3 | Prescale select: division ratio is 2^(preSel+1) |
| periodVal | input | 10 | Period value; a cycle lasts periodVal+1 ticks |
| dutyVal | input | 10 | Duty write buffer, taken into the latch at a boundary |
| flagClear | input | 1 | Clears the period flag |
| count | output | 10 | Current counter value (read only) |
| pwmOut | output | 1 | PWM output |
| periodFlag | output | 1 | Sticky period-boundary flag |

## Verification
The main function is exercised with duty values below the period, equal to zero, and above the period. These three cases separate a normal high-then-low waveform from an output that never rises and from one that never falls. Duty rewrites in the middle of a cycle show whether the write is buffered or taken in at once, because the high time of the current cycle exposes any early load. Several prescale codes, and gaps in cntEn, separate dividing by clock cycles from dividing by enable pulses. Disable pulses, and a clear that lands on a boundary, show which state is reset and which is kept.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic clear;    // force counter to zero (channel off)
    logic advance;  // ordinary tick: counter + 1
    logic wrap;     // boundary tick: counter to zero, load duty latch
  } ctrlStrobe_t;

  // compare results returned by the datapath
  typedef struct packed {
    logic atPeriod;     // counter equals period value
    logic nextHitsDuty; // counter + 1 equals latched duty
  } dpStatus_t;
endpackage

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] dutyVal,
  output dpStatus_t        status,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] dutyLatch;
  logic [CNT_W-1:0] cntPlusOne;

  assign cntPlusOne = cntQ + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      dutyLatch <= '0;
    end else if (strobe.clear) begin
      cntQ <= '0;
    end else if (strobe.wrap) begin
      cntQ      <= '0;
      dutyLatch <= dutyVal;
    end else if (strobe.advance) begin
      cntQ <= cntPlusOne;
    end
  end

  assign status.atPeriod     = (cntQ == periodVal);
  assign status.nextHitsDuty = (cntPlusOne == dutyLatch);
  assign count               = cntQ;
endmodule

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int PRE_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEn,
  input  logic                 chanEnable,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 flagClear,
  input  logic [CNT_W-1:0]     dutyVal,
  input  dpStatus_t            status,
  output ctrlStrobe_t          strobe,
  output logic                 pwmOut,
  output logic                 periodFlag
);
  localparam int PRE_W = 1 << PRE_SEL_W;

  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preTerm;
  logic [PRE_W:0]     preSpan;
  logic [PRE_SEL_W:0] preShift;
  logic               tick;
  logic               outQ;
  logic               flagQ;

  // terminal prescaler count: 2^(sel+1) - 1
  assign preShift = {1'b0, preSel} + 1'b1;
  assign preSpan  = ((PRE_W + 1)'(1) << preShift) - (PRE_W + 1)'(1);
  assign preTerm  = preSpan[PRE_W-1:0];
  assign tick     = chanEnable && cntEn && (preCnt >= preTerm);

  always_ff @(posedge clk) begin
    if (!rstN || !chanEnable) preCnt <= '0;
    else if (cntEn)           preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    strobe.clear   = !chanEnable;
    strobe.wrap    = tick && status.atPeriod;
    strobe.advance = tick && !status.atPeriod;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !chanEnable)                    outQ <= 1'b0;
    else if (strobe.wrap)                        outQ <= (dutyVal != '0);
    else if (strobe.advance && status.nextHitsDuty) outQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (strobe.wrap) flagQ <= 1'b1;
    else if (flagClear)   flagQ <= 1'b0;
  end

  assign pwmOut     = outQ;
  assign periodFlag = flagQ;
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int PRE_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEn,
  input  logic                 chanEnable,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic [CNT_W-1:0]     periodVal,
  input  logic [CNT_W-1:0]     dutyVal,
  input  logic                 flagClear,
  output logic [CNT_W-1:0]     count,
  output logic                 pwmOut,
  output logic                 periodFlag
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  pwm_timer_ctrl #(.CNT_W(CNT_W), .PRE_SEL_W(PRE_SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .chanEnable(chanEnable),
    .preSel(preSel), .flagClear(flagClear), .dutyVal(dutyVal),
    .status(status), .strobe(strobe), .pwmOut(pwmOut), .periodFlag(periodFlag)
  );

  pwm_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodVal(periodVal),
    .dutyVal(dutyVal), .status(status), .count(count)
  );
endmodule

// File: rtl/pwm_timer_channel_chk.sv
module pwm_timer_channel_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             chanEnable,
  input logic             flagClear,
  input logic [CNT_W-1:0] count,
  input logic             pwmOut,
  input logic             periodFlag
);
  AST_DISABLE_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> (count == '0) && !pwmOut); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && chanEnable) |=> $stable(count)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> ((count == '0) || (count == $past(count) + CNT_W'(1)))); // R3

  AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (count == '0)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (periodFlag && !flagClear) |=> periodFlag); // R7

  AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(periodFlag) |-> (count == '0)); // R7
endmodule

bind pwm_timer_channel pwm_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pwm_timer_channel_tb.sv
module pwm_timer_channel_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntEn = 1'b0;
  logic       chanEnable = 1'b0;
  logic [2:0] preSel = 3'd0;
  logic [9:0] periodVal = 10'd0;
  logic [9:0] dutyVal = 10'd0;
  logic       flagClear = 1'b0;
  logic [9:0] count;
  logic       pwmOut;
  logic       periodFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int  mPre = 0, mCnt = 0, mDl = 0;
  bit  mOut = 0, mFlag = 0;

  always #4 clk = ~clk;

  pwm_timer_channel u_dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .chanEnable(chanEnable),
    .preSel(preSel), .periodVal(periodVal), .dutyVal(dutyVal),
    .flagClear(flagClear), .count(count), .pwmOut(pwmOut), .periodFlag(periodFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    bit setFlag;
    setFlag = 0;
    cycles++;
    if (!rstN) begin
      mPre = 0; mCnt = 0; mDl = 0; mOut = 0; mFlag = 0;
    end else begin
      if (!chanEnable) begin
        mPre = 0; mCnt = 0; mOut = 0;
      end else if (cntEn) begin
        if (mPre >= (1 << (preSel + 1)) - 1) begin
          mPre = 0;
          if (mCnt == periodVal) begin
            mCnt = 0; mDl = dutyVal; mOut = (dutyVal != 0); setFlag = 1;
          end else begin
            mCnt = (mCnt + 1) % 1024;
            if (mCnt == mDl) mOut = 0;
          end
        end else mPre++;
      end
      if (setFlag) mFlag = 1;
      else if (flagClear) mFlag = 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check(count == 10'(mCnt), "R3 count", count, mCnt);
      check(pwmOut == mOut, "R5 pwmOut", pwmOut, mOut);
      check(periodFlag == mFlag, "R7 periodFlag", periodFlag, mFlag);
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // measure high clocks of one cycle starting at the next rising edge
  task automatic waitRise();
    int guard = 0;
    @(negedge clk);
    while (pwmOut && guard < 5000) begin @(negedge clk); guard++; end
    while (!pwmOut && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic highLen(output int hi);
    int guard = 0;
    hi = 0;
    while (pwmOut && guard < 5000) begin hi++; @(negedge clk); guard++; end
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, seen, c0;
    clocks(3);
    // R1: reset state
    check(count == 0 && !pwmOut && !periodFlag, "R1 reset", {count, pwmOut, periodFlag}, 0);
    rstN = 1'b1;
    periodVal = 10'd9; dutyVal = 10'd3; preSel = 3'd0;
    cntEn = 1'b1; chanEnable = 1'b1;
    waitRise(); // first boundary latches duty 3
    waitRise();
    c0 = cycles;
    highLen(hi);
    check(hi == 6, "R5 high time duty 3 div 2", hi, 6);
    waitRise();
    check(cycles - c0 == 20, "R3 cycle length 10 ticks div 2", cycles - c0, 20);

    // R6: mid-cycle duty write
    periodVal = 10'd19; dutyVal = 10'd5;
    waitRise(); waitRise();
    clocks(2); dutyVal = 10'd15;
    highLen(hi);
    check(hi == 8, "R6 current cycle keeps old duty", hi + 2, 10);
    waitRise();
    highLen(hi);
    check(hi == 30, "R6 next cycle uses new duty", hi, 30);

    // R4/R5: zero duty never rises
    dutyVal = 10'd0;
    waitRise();
    seen = 0;
    repeat (100) begin @(negedge clk); if (pwmOut) seen++; end
    check(seen == 0, "R4 zero duty keeps output low", seen, 0);

    // R5: duty above period stays high
    dutyVal = 10'd40; periodVal = 10'd7;
    repeat (40) @(negedge clk);
    seen = 0;
    repeat (50) begin @(negedge clk); if (!pwmOut) seen++; end
    check(seen == 0, "R5 oversize duty stays high", seen, 0);

    // R7: clear with counter frozen, then set again
    check(periodFlag == 1, "R7 flag set by boundary", periodFlag, 1);
    cntEn = 1'b0; flagClear = 1'b1;
    clocks(1); flagClear = 1'b0;
    check(periodFlag == 0, "R7 flag cleared", periodFlag, 0);
    cntEn = 1'b1;
    clocks(20);
    check(periodFlag == 1, "R7 flag set again", periodFlag, 1);
    // R7: clear held through boundaries, set wins
    flagClear = 1'b1;
    clocks(20);
    flagClear = 1'b0;
    clocks(1);

    // R8: disable
    chanEnable = 1'b0;
    clocks(1);
    check(count == 0 && !pwmOut, "R8 disable parks channel", count, 0);
    check(periodFlag == mFlag, "R8 flag kept while off", periodFlag, mFlag);
    clocks(5);

    // R2: divide by 8 from a clean start
    preSel = 3'd2; periodVal = 10'd50; dutyVal = 10'd4;
    chanEnable = 1'b1;
    clocks(7);
    check(count == 0, "R2 no step before 8 pulses", count, 0);
    clocks(1);
    check(count == 1, "R2 step after 8 pulses", count, 1);
    // R2: gaps in cntEn
    for (int i = 0; i < 60; i++) begin cntEn = (i % 3 != 0); clocks(1); end
    cntEn = 1'b1;
    // R2: largest divider
    preSel = 3'd7; periodVal = 10'd3; dutyVal = 10'd2;
    clocks(3000);
    // R8: disable mid-cycle again
    chanEnable = 1'b0; clocks(3); chanEnable = 1'b1;
    preSel = 3'd1; clocks(200);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule